// File: doc/BRIEF.md
# Truncating Single-Precision Floating-Point Multiplier

This block multiplies two IEEE-754 binary32 numbers in a single registered stage. Each operand is broken into its sign, its biased exponent and its stored fraction. The hidden leading one is put back in front of the fraction, and the two 24-bit significands are multiplied into a 48-bit product. The exponents are added and one bias is taken away. The result sign is the exclusive-OR of the operand signs.

The wide product needs at most one position of normalization. If its top bit is set, the leading one sits one place higher and the exponent goes up by one. The 23 bits just below the leading one become the result fraction. Every bit under them is dropped, with no rounding. An exponent that lands at or above the all-ones code gives a signed infinity and raises an overflow flag. An exponent at or below zero gives a signed zero and raises an underflow flag. An operand whose exponent field is zero counts as zero and gives a signed zero. Subnormal arithmetic, NaN handling and exception trapping are not part of this block.

A caller presents both operands with a valid strobe. The product, the flags and the valid strobe appear one clock later and stay unchanged until the next valid operation.

Top module: `fp32_mul_trunc`

## Requirements
- R1: The result fraction (bits 22:0 of `product`) holds the 23 bits just below the leading one of the 48-bit significand product. All lower bits are discarded without rounding. For example, 0x3F800001 times 0x3FE00000 gives 0x3FE00001.
- R2: The result sign (bit 31 of `product`) equals the exclusive-OR of bit 31 of `op_a` and bit 31 of `op_b` for every operation, including zero, overflow and underflow results.
- R3: For a normal result, the exponent field (bits 30:23) equals e_a + e_b - 127. One more is added when bit 47 of the significand product is set.
- R4: When the computed exponent is 255 or greater, `product` is {sign, 8'hFF, 23'h0}, `ovf` is 1 and `unf` is 0. This includes the case where the normalization increment alone reaches 255.
- R5: When the computed exponent is 0 or below, `product` is {sign, 8'h00, 23'h0}, `unf` is 1 and `ovf` is 0. A normalization increment that lifts the exponent to 1 gives a normal result with no flag.
- R6: When either operand has an exponent field of 0, `product` is {sign, 31'h0}, and both `ovf` and `unf` are 0, whatever the other operand is.
- R7: `valid_out` is 1 in exactly the cycle after a cycle with `valid_in` at 1. The matching result appears in that same cycle.
- R8: While `valid_in` is 0, `product`, `ovf` and `unf` keep their previous values.
- R9: While `rst` is high and after it is released, until the first valid operation, `valid_out`, `product`, `ovf` and `unf` are all 0.
- R10: `ovf` and `unf` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands present this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| valid_out | output | 1 | Result present this cycle |
| product | output | 32 | Truncated binary32 product |
| ovf | output | 1 | Result exponent overflowed; product is signed infinity |
| unf | output | 1 | Result exponent underflowed; product is signed zero |

## Verification
The properties assume that no operand has an exponent field of 255. Infinities and NaNs are outside this block's function, and such inputs would show up only as ordinary overflows. The stimulus table and the directed cases therefore take their operands from normal numbers and zeros only. The extreme operands used are the largest finite value and the smallest normal value, each paired with factors that push the exponent exactly to 255, to 0, or one step away from each limit. These include the cases where the normalization increment alone decides the outcome.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;

    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int EXT_W   = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              is_zero;
    } fp_parts_t;

    typedef enum logic [1:0] {
        RES_NORMAL = 2'd0,
        RES_ZERO   = 2'd1,
        RES_OVF    = 2'd2,
        RES_UNF    = 2'd3
    } res_kind_t;

    function automatic fp_word_t make_inf(input logic s);
        fp_word_t w;
        w.sign = s;
        w.exp  = '1;
        w.frac = '0;
        return w;
    endfunction

    function automatic fp_word_t make_zero(input logic s);
        fp_word_t w;
        w.sign = s;
        w.exp  = '0;
        w.frac = '0;
        return w;
    endfunction

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  fp_word_t  word_i,
    output fp_parts_t parts_o
);
    always_comb begin
        parts_o.sign    = word_i.sign;
        parts_o.exp     = word_i.exp;
        parts_o.is_zero = (word_i.exp == '0);
        parts_o.sig     = {~parts_o.is_zero, word_i.frac};
    end
endmodule

// File: rtl/fpm_sig_mul.sv
module fpm_sig_mul #(
    parameter int W = 24
) (
    input  logic [W-1:0]   x_i,
    input  logic [W-1:0]   y_i,
    output logic [2*W-1:0] p_o
);
    always_comb begin
        p_o = (2*W)'(x_i) * (2*W)'(y_i);
    end
endmodule

// File: rtl/fpm_norm_pack.sv
module fpm_norm_pack
    import fpm_pkg::*;
(
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_a_i,
    input  logic [EXP_W-1:0]  exp_b_i,
    input  logic [PROD_W-1:0] prod_i,
    input  logic              zero_i,
    output fp_word_t          word_o,
    output res_kind_t         kind_o
);
    localparam logic signed [EXT_W-1:0] BIAS_X = EXT_W'(BIAS);
    localparam logic signed [EXT_W-1:0] TOP_X  = EXT_W'(EXP_TOP);

    logic                     carry;
    logic signed [EXT_W-1:0]  exp_sum;
    logic [FRAC_W-1:0]        frac_kept;

    always_comb begin
        carry     = prod_i[PROD_W-1];
        frac_kept = carry ? prod_i[PROD_W-2 -: FRAC_W]
                          : prod_i[PROD_W-3 -: FRAC_W];
        exp_sum   = $signed({2'b00, exp_a_i}) + $signed({2'b00, exp_b_i})
                    - BIAS_X + $signed(EXT_W'(carry));

        if (zero_i)
            kind_o = RES_ZERO;
        else if (exp_sum >= TOP_X)
            kind_o = RES_OVF;
        else if (exp_sum <= 0)
            kind_o = RES_UNF;
        else
            kind_o = RES_NORMAL;

        unique case (kind_o)
            RES_OVF:    word_o = make_inf(sign_i);
            RES_ZERO,
            RES_UNF:    word_o = make_zero(sign_i);
            default: begin
                word_o.sign = sign_i;
                word_o.exp  = exp_sum[EXP_W-1:0];
                word_o.frac = frac_kept;
            end
        endcase
    end
endmodule

// File: rtl/fp32_mul_trunc.sv
module fp32_mul_trunc
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              valid_out,
    output logic [WORD_W-1:0] product,
    output logic              ovf,
    output logic              unf
);
    localparam int N_OPS = 2;

    fp_word_t          words [N_OPS];
    fp_parts_t         parts [N_OPS];
    logic [PROD_W-1:0] sig_prod;
    fp_word_t          res_word;
    res_kind_t         res_kind;

    assign words[0] = fp_word_t'(op_a);
    assign words[1] = fp_word_t'(op_b);

    for (genvar g = 0; g < N_OPS; g++) begin : g_unpack
        fpm_unpack u_unpack (
            .word_i  (words[g]),
            .parts_o (parts[g])
        );
    end

    fpm_sig_mul #(.W(SIG_W)) u_mul (
        .x_i (parts[0].sig),
        .y_i (parts[1].sig),
        .p_o (sig_prod)
    );

    fpm_norm_pack u_norm (
        .sign_i  (parts[0].sign ^ parts[1].sign),
        .exp_a_i (parts[0].exp),
        .exp_b_i (parts[1].exp),
        .prod_i  (sig_prod),
        .zero_i  (parts[0].is_zero | parts[1].is_zero),
        .word_o  (res_word),
        .kind_o  (res_kind)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            product   <= '0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                product <= res_word;
                ovf     <= (res_kind == RES_OVF);
                unf     <= (res_kind == RES_UNF);
            end
        end
    end
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker
    import fpm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_in,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              valid_out,
    input logic [WORD_W-1:0] product,
    input logic              ovf,
    input logic              unf
);
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R7
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(product) && $stable(ovf) && $stable(unf)));

    // R2
    sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (product[WORD_W-1] == ($past(op_a[WORD_W-1]) ^ $past(op_b[WORD_W-1]))));

    // R4
    ovf_inf_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (product[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    // R5
    unf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        unf |-> (product[WORD_W-2:0] == '0));

    // R6
    zero_op_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && (op_a[WORD_W-2 -: EXP_W] == '0 || op_b[WORD_W-2 -: EXP_W] == '0))
        |=> (product[WORD_W-2:0] == '0 && !ovf && !unf));

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        !(ovf && unf));
endmodule

bind fp32_mul_trunc fpm_checker i_fpm_checker (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .op_a      (op_a),
    .op_b      (op_b),
    .valid_out (valid_out),
    .product   (product),
    .ovf       (ovf),
    .unf       (unf)
);

// File: tb/test_fp32_mul_trunc.sv
module test_fp32_mul_trunc;

    logic        clk = 1'b0;
    logic        rst;
    logic        valid_in;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        valid_out;
    logic [31:0] product;
    logic        ovf;
    logic        unf;

    int n_cmp = 0;
    int n_bad = 0;

    always #4ns clk = ~clk;

    fp32_mul_trunc i_fp32_mul_trunc (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .op_a      (op_a),
        .op_b      (op_b),
        .valid_out (valid_out),
        .product   (product),
        .ovf       (ovf),
        .unf       (unf)
    );

    // {a, b, expected product, ovf, unf}
    localparam int NV = 18;
    localparam logic [97:0] VEC [NV] = '{
        {32'h3F800000, 32'h3F800000, 32'h3F800000, 1'b0, 1'b0}, // R3 1*1
        {32'h40000000, 32'h40400000, 32'h40C00000, 1'b0, 1'b0}, // R3 2*3
        {32'h3FC00000, 32'h3FC00000, 32'h40100000, 1'b0, 1'b0}, // R3 carry bit 47
        {32'hC0000000, 32'h3F000000, 32'hBF800000, 1'b0, 1'b0}, // R2 negative
        {32'hC0400000, 32'hC0000000, 32'h40C00000, 1'b0, 1'b0}, // R2 neg*neg
        {32'h3F800001, 32'h3FE00000, 32'h3FE00001, 1'b0, 1'b0}, // R1 truncation
        {32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFE, 1'b0, 1'b0}, // R1 all-ones frac
        {32'h7F000000, 32'h40000000, 32'h7F800000, 1'b1, 1'b0}, // R4 exp 255
        {32'hFF000000, 32'h40000000, 32'hFF800000, 1'b1, 1'b0}, // R4 neg inf
        {32'h7F400000, 32'h3FC00000, 32'h7F800000, 1'b1, 1'b0}, // R4 via carry
        {32'h7F000000, 32'h3F800000, 32'h7F000000, 1'b0, 1'b0}, // R4 edge 254
        {32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 1'b0, 1'b0}, // R1 max finite
        {32'h00800000, 32'h3F000000, 32'h00000000, 1'b0, 1'b1}, // R5 exp 0
        {32'h80800000, 32'h3F000000, 32'h80000000, 1'b0, 1'b1}, // R5 neg zero
        {32'h00C00000, 32'h3F400000, 32'h00900000, 1'b0, 1'b0}, // R5 carry rescues
        {32'h00800000, 32'h3F800000, 32'h00800000, 1'b0, 1'b0}, // R5 edge exp 1
        {32'h80000000, 32'h40000000, 32'h80000000, 1'b0, 1'b0}, // R6 signed zero
        {32'h00000000, 32'h7F7FFFFF, 32'h00000000, 1'b0, 1'b0}  // R6 zero*max
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin : watchdog
        #(8ns * 50000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        rst      = 1'b1;
        valid_in = 1'b0;
        op_a     = '0;
        op_b     = '0;
        repeat (3) @(negedge clk);
        // R9 during reset
        check("R9 valid", 32'(valid_out), 32'd0);
        check("R9 product", product, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        // R9 after release
        check("R9 flags", {30'd0, ovf, unf}, 32'd0);
        check("R9 idle valid", 32'(valid_out), 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][97:66], VEC[i][65:34]);
            check("R7 valid_out", 32'(valid_out), 32'd1);
            check($sformatf("R1-R6 vec%0d product", i), product, VEC[i][33:2]);
            check($sformatf("R4/R5 vec%0d flags", i), {30'd0, ovf, unf}, {30'd0, VEC[i][1:0]});
            check("R10 exclusive flags", 32'(ovf & unf), 32'd0);
        end

        // R7 valid drops after one cycle; R8 hold with changing operands
        apply(32'h7F000000, 32'h40000000);
        op_a = 32'h3F800000;
        op_b = 32'h00000000;
        @(negedge clk);
        check("R7 valid low", 32'(valid_out), 32'd0);
        check("R8 product held", product, 32'h7F800000);
        check("R8 ovf held", 32'(ovf), 32'd1);
        @(negedge clk);
        check("R8 still held", product, 32'h7F800000);

        // R7 back-to-back operations
        @(negedge clk);
        op_a = 32'h40000000; op_b = 32'h40000000; valid_in = 1'b1;
        @(negedge clk);
        check("R7 b2b first", product, 32'h40800000);
        op_a = 32'hBF800000; op_b = 32'h40400000;
        @(negedge clk);
        valid_in = 1'b0;
        check("R7 b2b second", product, 32'hC0400000);
        check("R7 b2b valid", 32'(valid_out), 32'd1);

        // R9 reset clears a held result
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset clears", product, 32'd0);
        rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule